// File: doc/BRIEF.md
# Three-Channel Register-Mapped Watchdog

This peripheral holds three independent watchdog channels behind one 32-bit register window. Each channel has an up-counter that advances on a reference tick, a reset threshold and a control word. When a channel is armed and its counter has reached or passed its threshold, it raises a reset request. Channel 0 raises a recovery-mode reset request. Channels 1 and 2 share a normal system reset request.

Channel 0 also has a second threshold that drives an interrupt. When that threshold is met and the interrupt is enabled, a sticky status flag is set. The flag stays set until software writes one to it. Software keeps a channel alive by writing zero to its counter. It can load the counter with any value, which allows immediate resets or quick tests. The reset sequencer that acts on the requests lies outside this block.

Top module: `triple_watchdog`

## Requirements
- R1: The address is decoded word-aligned. Bits 7:4 select the channel (0, 1 or 2) and bits 3:2 select the register: 0 is the counter, 1 the reset threshold, 2 the interrupt threshold (channel 0 only), 3 the control word. Written values read back unchanged.
- R2: Control word bit 0 is the interrupt enable, bit 1 the interrupt status and bit 2 the reset arm. Bits 31:3 read as zero. On channels 1 and 2, bits 1:0 also read as zero.
- R3: After power-on reset, every counter, threshold and control bit is zero, and all three outputs are low.
- R4: On each clock with `tick_en` high, every counter not written in that cycle increases by one.
- R5: A write to a counter loads the written value and takes precedence over a tick in the same cycle. Writing zero is the keep-alive.
- R6: A channel's reset request is a level. It is high whenever the channel is armed and its counter is greater than or equal to its threshold, compared unsigned. It follows one clock after the write that creates the condition.
- R7: Channel 0 drives `rst_recovery_req`. `rst_system_req` is the OR of the requests of channels 1 and 2.
- R8: On channel 0, the status flag and `irq` are set one clock after a cycle in which the interrupt enable is set and the counter is at or above the interrupt threshold.
- R9: Writing one to the status bit clears it unless the set condition holds in that same cycle, in which case setting wins. Writing zero to it leaves it unchanged. The flag stays set after the condition goes away.
- R10: A counter at 0xFFFFFFFF wraps to 0 on the next tick.
- R11: Clearing the reset arm drops that channel's request one clock after the write.
- R12: Offsets with no register (0x18, 0x28, channel field 3 or above) read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Reference tick, one count per high clock |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_recovery_req | output | 1 | Recovery-mode reset request from channel 0 |
| rst_system_req | output | 1 | Normal reset request from channel 1 or 2 |
| irq | output | 1 | Channel 0 interrupt, follows the status flag |

## Verification
Two functions can meet in one clock on channel 0: setting the interrupt status and clearing it by a write-one. The bench drives the counter up to the interrupt threshold and waits until the flag is set. It then writes one to the status bit while the counter still sits on the threshold, and it expects `irq` to remain high. It then moves the counter below the threshold with a keep-alive and repeats the write-one. Here it expects the flag to drop, which shows that the clear itself works and that the set condition was what held it in the first case.

// File: rtl/twd_pkg.sv
package twd_pkg;
  localparam int WORD_W = 32;
  localparam int SLOTS  = 4;

  typedef enum logic [1:0] {
    SLOT_COUNT = 2'd0,
    SLOT_RCMP  = 2'd1,
    SLOT_ICMP  = 2'd2,
    SLOT_CTRL  = 2'd3
  } slot_e;

  localparam int CTL_IEN = 0;
  localparam int CTL_IST = 1;
  localparam int CTL_REN = 2;
endpackage

// File: rtl/twd_rst_sync.sv
module twd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/twd_decode.sv
module twd_decode
  import twd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 3,
  localparam int CH_W  = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    we,
  output slot_e                   slot,
  output logic [CH_W-1:0]         ch,
  output logic                    hit,
  output logic [NUM_CH*SLOTS-1:0] wr_stb
);
  assign slot = slot_e'(addr[3:2]);
  assign ch   = addr[ADDR_W-1:4];
  assign hit  = (ch < CH_W'(NUM_CH));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_stb
    assign wr_stb[g*SLOTS +: SLOTS] =
      (we && hit && ch == CH_W'(g)) ? (SLOTS'(1) << slot) : '0;
  end
endmodule

// File: rtl/twd_channel.sv
module twd_channel
  import twd_pkg::*;
#(
  parameter int DW      = 32,
  parameter bit HAS_IRQ = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [SLOTS-1:0] wr_stb,
  input  logic [DW-1:0]    wdata,
  input  slot_e            rd_slot,
  output logic [DW-1:0]    rd_data,
  output logic             rst_req,
  output logic             irq
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rcmp_q, rcmp_d;
  logic          ren_q, ren_d;
  logic [DW-1:0] icmp_rd;
  logic          ien_rd, ist_rd;

  always_comb begin
    cnt_d  = cnt_q;
    rcmp_d = rcmp_q;
    ren_d  = ren_q;
    if (wr_stb[SLOT_COUNT])  cnt_d = wdata;
    else if (tick_en)        cnt_d = cnt_q + DW'(1);
    if (wr_stb[SLOT_RCMP])   rcmp_d = wdata;
    if (wr_stb[SLOT_CTRL])   ren_d  = wdata[CTL_REN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rcmp_q <= '0;
      ren_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rcmp_q <= rcmp_d;
      ren_q  <= ren_d;
    end
  end

  assign rst_req = ren_q && (cnt_q >= rcmp_q);

  if (HAS_IRQ) begin : g_irq
    logic [DW-1:0] icmp_q, icmp_d;
    logic          ien_q, ien_d;
    logic          ist_q, ist_d;
    logic          set_now, clr_now;

    always_comb begin
      set_now = ien_q && (cnt_q >= icmp_q);
      clr_now = wr_stb[SLOT_CTRL] && wdata[CTL_IST];
      icmp_d  = wr_stb[SLOT_ICMP] ? wdata : icmp_q;
      ien_d   = wr_stb[SLOT_CTRL] ? wdata[CTL_IEN] : ien_q;
      ist_d   = set_now | (ist_q & ~clr_now);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        icmp_q <= '0;
        ien_q  <= 1'b0;
        ist_q  <= 1'b0;
      end else begin
        icmp_q <= icmp_d;
        ien_q  <= ien_d;
        ist_q  <= ist_d;
      end
    end

    assign icmp_rd = icmp_q;
    assign ien_rd  = ien_q;
    assign ist_rd  = ist_q;
    assign irq     = ist_q;

    // R9: flag holds unless a write-one arrives
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ist_q && !(wr_stb[SLOT_CTRL] && wdata[CTL_IST])) |=> ist_q);
    // R8: threshold met with enable gives the flag next clock
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q && cnt_q >= icmp_q) |=> irq);
  end else begin : g_noirq
    assign icmp_rd = '0;
    assign ien_rd  = 1'b0;
    assign ist_rd  = 1'b0;
    assign irq     = 1'b0;
  end

  always_comb begin
    unique case (rd_slot)
      SLOT_COUNT: rd_data = cnt_q;
      SLOT_RCMP:  rd_data = rcmp_q;
      SLOT_ICMP:  rd_data = icmp_rd;
      default:    rd_data = {{(DW-3){1'b0}}, ren_q, ist_rd, ien_rd};
    endcase
  end

  // R5: a counter write loads the value regardless of the tick
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[SLOT_COUNT] |=> cnt_q == $past(wdata));
  // R4: a tick without a write steps by one
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_stb[SLOT_COUNT]) |=> cnt_q == $past(cnt_q) + DW'(1));
  // R11: disarming silences the request next clock
  a_r11_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb[SLOT_CTRL] && !wdata[CTL_REN]) |=> !rst_req);
endmodule

// File: rtl/triple_watchdog.sv
module triple_watchdog
  import twd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 3,
  parameter int DW     = WORD_W,
  localparam int CH_W  = ADDR_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              rst_recovery_req,
  output logic              rst_system_req,
  output logic              irq
);
  logic                    rst_n_int;
  slot_e                   slot;
  logic [CH_W-1:0]         ch;
  logic                    hit;
  logic [NUM_CH*SLOTS-1:0] wr_stb;
  logic [DW-1:0]           rd_arr [NUM_CH];
  logic [NUM_CH-1:0]       req_vec;
  logic [NUM_CH-1:0]       irq_vec;

  twd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  twd_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr(bus_addr), .we(bus_we), .slot(slot), .ch(ch), .hit(hit), .wr_stb(wr_stb)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    twd_channel #(.DW(DW), .HAS_IRQ(g == 0)) u_ch (
      .clk(clk), .rst_n(rst_n_int), .tick_en(tick_en),
      .wr_stb(wr_stb[g*SLOTS +: SLOTS]), .wdata(bus_wdata),
      .rd_slot(slot), .rd_data(rd_arr[g]),
      .rst_req(req_vec[g]), .irq(irq_vec[g])
    );
  end

  always_comb begin
    bus_rdata      = '0;
    rst_system_req = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit && ch == CH_W'(i)) bus_rdata = rd_arr[i];
      if (i > 0) rst_system_req = rst_system_req | req_vec[i];
    end
  end

  assign rst_recovery_req = req_vec[0];
  assign irq              = |irq_vec;

  // R12: holes in the window read as zero
  a_r12_hole_zero: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!hit || (ch != '0 && slot == SLOT_ICMP)) |-> bus_rdata == '0);
endmodule

// File: tb/triple_watchdog_bench.sv
module triple_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_recovery_req, rst_system_req, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  triple_watchdog u_triple_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_recovery_req(rst_recovery_req), .rst_system_req(rst_system_req), .irq(irq)
  );

  // vector: {we, addr, wdata, expected read, expected system request}
  localparam int NV = 19;
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0,        32'h0, 1'b0},
    {1'b1, 8'h14, 32'd5,        32'h0, 1'b0},
    {1'b0, 8'h14, 32'h0,        32'd5, 1'b0},
    {1'b1, 8'h1C, 32'hFFFFFFFF, 32'h0, 1'b0},
    {1'b0, 8'h1C, 32'h0,        32'h4, 1'b0},
    {1'b1, 8'h10, 32'd7,        32'h0, 1'b1},
    {1'b0, 8'h10, 32'h0,        32'd7, 1'b1},
    {1'b1, 8'h10, 32'h0,        32'h0, 1'b0},
    {1'b1, 8'h10, 32'd5,        32'h0, 1'b1},
    {1'b1, 8'h1C, 32'h0,        32'h0, 1'b0},
    {1'b1, 8'h18, 32'h1234,     32'h0, 1'b0},
    {1'b0, 8'h18, 32'h0,        32'h0, 1'b0},
    {1'b1, 8'h24, 32'd3,        32'h0, 1'b0},
    {1'b1, 8'h20, 32'hFFFFFFFF, 32'h0, 1'b0},
    {1'b1, 8'h2C, 32'h4,        32'h0, 1'b1},
    {1'b0, 8'h2C, 32'h0,        32'h4, 1'b1},
    {1'b1, 8'h2C, 32'h0,        32'h0, 1'b0},
    {1'b0, 8'h30, 32'h0,        32'h0, 1'b0},
    {1'b0, 8'h24, 32'h0,        32'd3, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: power-on state
    chk("R3 recovery after reset", {31'b0, rst_recovery_req}, 32'h0);
    chk("R3 system after reset", {31'b0, rst_system_req}, 32'h0);
    chk("R3 irq after reset", {31'b0, irq}, 32'h0);
    bus_read(8'h0C, rd); chk("R3 ctrl0 zero", rd, 32'h0);
    bus_read(8'h04, rd); chk("R3 rcmp0 zero", rd, 32'h0);

    // Table: R1 R2 R5 R6 R7 R11 R12 with ticks held off
    for (int i = 0; i < NV; i++) begin
      logic [73:0] v;
      v = VEC[i];
      if (v[73]) bus_write(v[72:65], v[64:33]);
      else begin
        bus_read(v[72:65], rd);
        chk($sformatf("R1/R2/R12 read vec %0d", i), rd, v[32:1]);
      end
      chk($sformatf("R6/R7/R11 system req vec %0d", i), {31'b0, rst_system_req}, {31'b0, v[0]});
      chk($sformatf("R7 recovery quiet vec %0d", i), {31'b0, rst_recovery_req}, 32'h0);
    end

    // R12: hole write changed nothing in channel 1
    bus_read(8'h14, rd); chk("R12 rcmp1 intact", rd, 32'd5);

    // R4: tick counting
    bus_write(8'h20, 32'h0);
    run_ticks(25);
    bus_read(8'h20, rd); chk("R4 count after 25 ticks", rd, 32'd25);

    // R10: wrap
    bus_write(8'h10, 32'hFFFFFFFF);
    run_ticks(1);
    bus_read(8'h10, rd); chk("R10 wrap to zero", rd, 32'h0);

    // R8: interrupt threshold
    bus_write(8'h08, 32'd10);
    bus_write(8'h00, 32'h0);
    bus_write(8'h0C, 32'h1);
    chk("R8 irq low below threshold", {31'b0, irq}, 32'h0);
    run_ticks(10);
    chk("R8 irq one clock after reaching threshold", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq set", {31'b0, irq}, 32'h1);
    bus_read(8'h0C, rd); chk("R2 ctrl0 enable and status", rd, 32'h3);
    bus_read(8'h00, rd); chk("R1 count0 readback", rd, 32'd10);

    // R9: clear collides with set condition, set wins
    bus_write(8'h0C, 32'h3);
    chk("R9 set wins over clear", {31'b0, irq}, 32'h1);
    bus_write(8'h0C, 32'h1);
    chk("R9 write zero keeps status", {31'b0, irq}, 32'h1);
    bus_write(8'h00, 32'h0);
    chk("R9 sticky after condition gone", {31'b0, irq}, 32'h1);
    bus_write(8'h0C, 32'h3);
    chk("R9 write one clears", {31'b0, irq}, 32'h0);

    // R6 R7: immediate recovery reset on channel 0
    bus_write(8'h04, 32'h0);
    bus_write(8'h0C, 32'h4);
    chk("R6 immediate recovery request", {31'b0, rst_recovery_req}, 32'h1);
    chk("R7 system stays low", {31'b0, rst_system_req}, 32'h0);
    bus_write(8'h0C, 32'h0);
    chk("R11 recovery drops on disarm", {31'b0, rst_recovery_req}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule